// File: doc/BRIEF.md
# Programmable Memory BAR Decoder

This block is the address-claim stage of a bus target. It holds the base address registers that software places in the system address map. For each incoming address and cycle type, it reports which register claims the access and the offset inside that register's window. Two registers expose the block's own control space, one on I/O cycles and one on memory cycles. Each of these has a fixed window size and its own enable input. A parameterised number of further memory registers take their window size from a 4-bit code. The code selects a size from 2GB down to 16KB, or turns the register off. The three smallest sizes also mark the window as translated by a later windowing stage, which lives outside this block.

The configuration write port updates one register on the next clock edge. The read port returns the register's visible value in the same cycle. Address bits below the window size always read as zero, so the usual write-all-ones sizing probe reveals the size. A base of zero does not decode unless a global control input permits it. Decode is purely combinational from the address, the cycle type, the codes, the enables and the stored bases.

Top module: `bar_window_decoder`

## Requirements
- R1: A coded register (select 2 and up; its code is field `cfg_code[4k+3:4k]` for select k+2) with code 0 never hits and reads back 0.
- R2: Code c in 1..12 gives a window of 2^(32-c) bytes; writing all ones then reads back ones only at bits 31 down to 32-c.
- R3: Codes 13, 14 and 15 give 64KB, 32KB and 16KB windows, and `hit_windowed` is 1 on a hit to such a register. On a hit to any other register, or on no hit, it is 0.
- R4: A register whose masked base is zero does not hit while `cfg_allow_zero` is 0, and does hit while it is 1.
- R5: The register I/O BAR (select 0, 2^IO_LOG2 bytes) reads back 0 and never hits while `cfg_io_en` is 0, even after a write. While the enable is 1, it reads back its stored value with the bits below the size cleared.
- R6: The register memory BAR (select 1, 2^REGMEM_LOG2 bytes) hits only while `cfg_regmem_en` is 1, and its readback does not depend on that enable. Select 0 responds only to I/O cycles (`req_is_io`=1); every other select responds only to memory cycles.
- R7: A register hits only when the address bits at and above its size equal its base. `hit_offset` is the address with those bits cleared, or 0 when nothing hits.
- R8: When several registers match, the lowest select wins. `hit_vec` (bit i = select i) is always one-hot or zero, and `hit_any` is its OR.
- R9: A configuration write is visible on the read port and in decode from the clock edge that samples it, not before. Reads are combinational.
- R10: After reset every stored base is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_allow_zero | input | 1 | Permit decode of a zero base |
| cfg_io_en | input | 1 | Enable of the register I/O BAR |
| cfg_regmem_en | input | 1 | Enable of the register memory BAR |
| cfg_code | input | 4*NUM_CODED | Size/disable code for each coded BAR |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_sel | input | SEL_W | Select of the BAR being written |
| cfg_wr_data | input | 32 | Write data |
| cfg_rd_sel | input | SEL_W | Select of the BAR being read |
| cfg_rd_data | output | 32 | Visible value of the selected BAR |
| req_addr | input | 32 | Address under decode |
| req_is_io | input | 1 | 1 for an I/O cycle, 0 for memory |
| hit_vec | output | NBARS | One-hot claiming BAR |
| hit_any | output | 1 | Some BAR claims the access |
| hit_offset | output | 32 | Offset inside the claiming window |
| hit_windowed | output | 1 | Claiming window uses internal windowing |

## Verification
Two functions can act in the same cycle: priority selection among overlapping windows, and a configuration write that moves one of those windows. The bench makes a 2GB window and a 16KB window overlap on one address, so the lower select must win with the 2GB offset. It then turns the lower register off and expects the claim to pass to the higher select, with the windowing flag set. Around every write, the read port and decode are sampled once before the capturing edge, where the old value is expected, and once after it, where the new value is expected.

// File: rtl/bar_dec_pkg.sv
package bar_dec_pkg;
   localparam int ADDR_W = 32;
   localparam int CODE_W = 4;
   localparam int LOG2_W = 6;

   // Window size (log2 bytes) for a size code; 0 for the off code.
   function automatic logic [LOG2_W-1:0] code_to_log2(input logic [CODE_W-1:0] c);
      logic [LOG2_W-1:0] r;
      case (c)
         4'h0:    r = '0;
         4'hD:    r = 6'd16;
         4'hE:    r = 6'd15;
         4'hF:    r = 6'd14;
         default: r = 6'd32 - LOG2_W'(c);
      endcase
      return r;
   endfunction

   function automatic logic code_windowed(input logic [CODE_W-1:0] c);
      return (c >= 4'hD);
   endfunction
endpackage

// File: rtl/bar_slot.sv
module bar_slot
   import bar_dec_pkg::*;
#(
   parameter bit IS_CODED   = 1'b1,
   parameter int FIXED_LOG2 = 12,
   parameter bit IS_IO      = 1'b0,
   parameter bit GATE_READ  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] code,
   input  logic              en,
   input  logic              allow_zero,
   input  logic              wr,
   input  logic [ADDR_W-1:0] wdata,
   input  logic [ADDR_W-1:0] addr,
   input  logic              is_io,
   output logic              match,
   output logic [ADDR_W-1:0] rdata,
   output logic [ADDR_W-1:0] mask,
   output logic              windowed
);
   logic [ADDR_W-1:0] base_q;
   logic [LOG2_W-1:0] sz;
   logic              active;
   logic              read_on;
   logic [ADDR_W-1:0] base_m;

   generate
      if (IS_CODED) begin : g_coded
         assign active   = (code != '0);
         assign sz       = code_to_log2(code);
         assign windowed = code_windowed(code);
         assign read_on  = active;
      end else begin : g_fixed
         if (FIXED_LOG2 < 2 || FIXED_LOG2 > 31) begin : g_bad
            $error("bar_slot: FIXED_LOG2 out of range");
         end
         assign active   = en;
         assign sz       = LOG2_W'(FIXED_LOG2);
         assign windowed = 1'b0;
         assign read_on  = GATE_READ ? en : 1'b1;
      end
   endgenerate

   assign mask   = {ADDR_W{1'b1}} << sz;
   assign base_m = base_q & mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) base_q <= '0;
      else if (wr) base_q <= wdata;
   end

   assign rdata = read_on ? base_m : '0;
   assign match = active && (is_io == IS_IO) &&
                  ((addr & mask) == base_m) &&
                  (allow_zero || (base_m != '0));

   // R9: a write shows on the read side after the capturing edge
   a_r9_write_next: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (!read_on || rdata == ($past(wdata) & mask)));
   // R4: zero window never claims without permission
   a_r4_zero_base: assert property (@(posedge clk) disable iff (!rst_n)
      (match && !allow_zero) |-> ((addr & mask) != '0));
   // R6: cycle type gate
   a_r6_cycle_type: assert property (@(posedge clk) disable iff (!rst_n)
      (is_io != IS_IO) |-> !match);
endmodule

// File: rtl/bar_prio_pick.sv
module bar_prio_pick
   import bar_dec_pkg::*;
#(
   parameter int N = 6
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [N-1:0]              match,
   input  logic [N-1:0][ADDR_W-1:0]  masks,
   input  logic [N-1:0]              win,
   input  logic [ADDR_W-1:0]         addr,
   output logic [N-1:0]              hit_vec,
   output logic                      hit_any,
   output logic [ADDR_W-1:0]         offset,
   output logic                      windowed
);
   always_comb begin
      hit_vec  = '0;
      offset   = '0;
      windowed = 1'b0;
      for (int i = N-1; i >= 0; i--) begin
         if (match[i]) begin
            hit_vec  = '0;
            hit_vec[i] = 1'b1;
            offset   = addr & ~masks[i];
            windowed = win[i];
         end
      end
   end
   assign hit_any = |hit_vec;

   // R8: single claimant
   a_r8_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));
   // R8: lowest matching select wins
   a_r8_lowest: assert property (@(posedge clk) disable iff (!rst_n)
      match[0] |-> hit_vec[0]);
   // R7: no claim, no offset
   a_r7_idle_offset: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_any |-> (offset == '0 && !windowed));
endmodule

// File: rtl/bar_window_decoder.sv
module bar_window_decoder
   import bar_dec_pkg::*;
#(
   parameter int NUM_CODED   = 4,
   parameter int IO_LOG2     = 8,
   parameter int REGMEM_LOG2 = 12,
   localparam int NBARS      = NUM_CODED + 2,
   localparam int SEL_W      = $clog2(NBARS)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cfg_allow_zero,
   input  logic                          cfg_io_en,
   input  logic                          cfg_regmem_en,
   input  logic [NUM_CODED*CODE_W-1:0]   cfg_code,
   input  logic                          cfg_wr_en,
   input  logic [SEL_W-1:0]              cfg_wr_sel,
   input  logic [ADDR_W-1:0]             cfg_wr_data,
   input  logic [SEL_W-1:0]              cfg_rd_sel,
   output logic [ADDR_W-1:0]             cfg_rd_data,
   input  logic [ADDR_W-1:0]             req_addr,
   input  logic                          req_is_io,
   output logic [NBARS-1:0]              hit_vec,
   output logic                          hit_any,
   output logic [ADDR_W-1:0]             hit_offset,
   output logic                          hit_windowed
);
   generate
      if (NUM_CODED < 1 || NUM_CODED > 13) begin : g_bad_n
         $error("bar_window_decoder: NUM_CODED out of range");
      end
   endgenerate

   logic [NBARS-1:0]             match;
   logic [NBARS-1:0]             win;
   logic [NBARS-1:0][ADDR_W-1:0] masks;
   logic [NBARS-1:0][ADDR_W-1:0] rdata;
   logic [NBARS-1:0]             wr;

   always_comb begin
      wr = '0;
      if (cfg_wr_en && (int'(cfg_wr_sel) < NBARS)) wr[cfg_wr_sel] = 1'b1;
   end

   bar_slot #(.IS_CODED(1'b0), .FIXED_LOG2(IO_LOG2), .IS_IO(1'b1), .GATE_READ(1'b1)) u_io (
      .clk(clk), .rst_n(rst_n), .code('0), .en(cfg_io_en), .allow_zero(cfg_allow_zero),
      .wr(wr[0]), .wdata(cfg_wr_data), .addr(req_addr), .is_io(req_is_io),
      .match(match[0]), .rdata(rdata[0]), .mask(masks[0]), .windowed(win[0]));

   bar_slot #(.IS_CODED(1'b0), .FIXED_LOG2(REGMEM_LOG2), .IS_IO(1'b0), .GATE_READ(1'b0)) u_regmem (
      .clk(clk), .rst_n(rst_n), .code('0), .en(cfg_regmem_en), .allow_zero(cfg_allow_zero),
      .wr(wr[1]), .wdata(cfg_wr_data), .addr(req_addr), .is_io(req_is_io),
      .match(match[1]), .rdata(rdata[1]), .mask(masks[1]), .windowed(win[1]));

   generate
      for (genvar k = 0; k < NUM_CODED; k++) begin : g_coded
         bar_slot #(.IS_CODED(1'b1), .FIXED_LOG2(12), .IS_IO(1'b0), .GATE_READ(1'b0)) u_slot (
            .clk(clk), .rst_n(rst_n), .code(cfg_code[k*CODE_W +: CODE_W]), .en(1'b0),
            .allow_zero(cfg_allow_zero), .wr(wr[k+2]), .wdata(cfg_wr_data),
            .addr(req_addr), .is_io(req_is_io), .match(match[k+2]),
            .rdata(rdata[k+2]), .mask(masks[k+2]), .windowed(win[k+2]));

         // R1: switched-off register never claims
         a_r1_off_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_code[k*CODE_W +: CODE_W] == '0) |-> !hit_vec[k+2]);
      end
   endgenerate

   assign cfg_rd_data = (int'(cfg_rd_sel) < NBARS) ? rdata[cfg_rd_sel] : '0;

   bar_prio_pick #(.N(NBARS)) u_pick (
      .clk(clk), .rst_n(rst_n), .match(match), .masks(masks), .win(win),
      .addr(req_addr), .hit_vec(hit_vec), .hit_any(hit_any),
      .offset(hit_offset), .windowed(hit_windowed));

   // R5: register I/O BAR silent while its enable is clear
   a_r5_io_off: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_io_en |-> !hit_vec[0]);
   // R6: register memory BAR silent while its enable is clear
   a_r6_regmem_off: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_regmem_en |-> !hit_vec[1]);
   // R3: only a small coded window raises the windowing flag
   a_r3_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
      hit_windowed |-> (hit_any && !hit_vec[0] && !hit_vec[1]));
endmodule

// File: tb/sim_bar_window_decoder.sv
module sim_bar_window_decoder;
   localparam int NC = 4;
   localparam int NB = NC + 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_allow_zero = 1'b0;
   logic        cfg_io_en = 1'b0;
   logic        cfg_regmem_en = 1'b0;
   logic [NC*4-1:0] cfg_code = '0;
   logic        cfg_wr_en = 1'b0;
   logic [2:0]  cfg_wr_sel = '0;
   logic [31:0] cfg_wr_data = '0;
   logic [2:0]  cfg_rd_sel = '0;
   logic [31:0] cfg_rd_data;
   logic [31:0] req_addr = '0;
   logic        req_is_io = 1'b0;
   logic [NB-1:0] hit_vec;
   logic        hit_any;
   logic [31:0] hit_offset;
   logic        hit_windowed;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   bar_window_decoder #(.NUM_CODED(NC)) u0 (.*);

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd(string req, int sel, logic [31:0] exp);
      cfg_rd_sel = 3'(sel);
      #1;
      check(req, cfg_rd_data, exp);
   endtask

   task automatic dec(string req, logic [31:0] a, logic io,
                      logic [NB-1:0] ev, logic [31:0] eo, logic ew);
      req_addr = a;
      req_is_io = io;
      #1;
      check({req, " hit_vec"}, 32'(hit_vec), 32'(ev));
      check({req, " hit_any"}, 32'(hit_any), 32'(ev != '0));
      check({req, " offset"}, hit_offset, eo);
      check({req, " windowed"}, 32'(hit_windowed), 32'(ew));
   endtask

   task automatic wr(int sel, logic [31:0] d);
      @(negedge clk);
      cfg_wr_en = 1'b1;
      cfg_wr_sel = 3'(sel);
      cfg_wr_data = d;
      @(negedge clk);
      cfg_wr_en = 1'b0;
   endtask

   task automatic set_code(int sel, logic [3:0] c);
      cfg_code[(sel-2)*4 +: 4] = c;
   endtask

   task automatic t_reset;
      for (int s = 0; s < NB; s++) rd("R10 reset read", s, 32'h0);
      cfg_io_en = 1'b1;
      cfg_regmem_en = 1'b1;
      rd("R10 reset io", 0, 32'h0);
      dec("R10 reset decode", 32'h0000_0010, 1'b0, '0, 32'h0, 1'b0);
      cfg_io_en = 1'b0;
      cfg_regmem_en = 1'b0;
   endtask

   task automatic t_write_timing;
      set_code(2, 4'h1);
      @(negedge clk);
      cfg_wr_en = 1'b1; cfg_wr_sel = 3'd2; cfg_wr_data = 32'h8000_0000;
      rd("R9 before edge", 2, 32'h0);
      @(negedge clk);
      cfg_wr_en = 1'b0;
      rd("R9 after edge", 2, 32'h8000_0000);
   endtask

   task automatic t_sizes;
      set_code(3, 4'hC);
      wr(3, 32'hFFFF_FFFF);
      rd("R2 code C size", 3, 32'hFFF0_0000);
      set_code(3, 4'h5);
      rd("R2 code 5 size", 3, 32'hF800_0000);
      set_code(4, 4'hD);
      wr(4, 32'h1234_5678);
      rd("R3 code D size", 4, 32'h1234_0000);
      set_code(5, 4'hF);
      wr(5, 32'hFFFF_FFFF);
      rd("R3 code F size", 5, 32'hFFFF_C000);
      set_code(5, 4'hE);
      rd("R3 code E size", 5, 32'hFFFF_8000);
      set_code(5, 4'hF);
      dec("R3 windowed hit", 32'h1234_ABCD, 1'b0, 6'b010000, 32'h0000_ABCD, 1'b1);
   endtask

   task automatic t_match;
      set_code(3, 4'hC);
      wr(3, 32'h4000_0000);
      rd("R7 base", 3, 32'h4000_0000);
      dec("R7 top of window", 32'h400F_FFFF, 1'b0, 6'b001000, 32'h000F_FFFF, 1'b0);
      dec("R7 past window", 32'h4010_0000, 1'b0, '0, 32'h0, 1'b0);
   endtask

   task automatic t_priority;
      dec("R8 overlap low wins", 32'hFFFF_C010, 1'b0, 6'b000100, 32'h7FFF_C010, 1'b0);
      set_code(2, 4'h0);
      rd("R1 off reads zero", 2, 32'h0);
      dec("R1 off passes claim", 32'hFFFF_C010, 1'b0, 6'b100000, 32'h0000_0010, 1'b1);
      dec("R1 off no hit", 32'h8000_0000, 1'b0, '0, 32'h0, 1'b0);
   endtask

   task automatic t_zero_base;
      wr(3, 32'h0);
      dec("R4 zero blocked", 32'h0001_2345, 1'b0, '0, 32'h0, 1'b0);
      cfg_allow_zero = 1'b1;
      dec("R4 zero allowed", 32'h0001_2345, 1'b0, 6'b001000, 32'h0001_2345, 1'b0);
      cfg_allow_zero = 1'b0;
   endtask

   task automatic t_io;
      wr(0, 32'h0000_ABCD);
      rd("R5 gated read", 0, 32'h0);
      dec("R5 gated decode", 32'h0000_AB10, 1'b1, '0, 32'h0, 1'b0);
      cfg_io_en = 1'b1;
      rd("R5 enabled read", 0, 32'h0000_AB00);
      dec("R5 io hit", 32'h0000_AB10, 1'b1, 6'b000001, 32'h0000_0010, 1'b0);
      dec("R6 io bar ignores memory", 32'h0000_AB10, 1'b0, '0, 32'h0, 1'b0);
   endtask

   task automatic t_regmem;
      wr(1, 32'h0020_0FFF);
      rd("R6 regmem read while off", 1, 32'h0020_0000);
      dec("R6 regmem off", 32'h0020_0ABC, 1'b0, '0, 32'h0, 1'b0);
      cfg_regmem_en = 1'b1;
      dec("R6 regmem on", 32'h0020_0ABC, 1'b0, 6'b000010, 32'h0000_0ABC, 1'b0);
      dec("R6 regmem ignores io", 32'h0020_0ABC, 1'b1, '0, 32'h0, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_write_timing;
      t_sizes;
      t_match;
      t_priority;
      t_zero_base;
      t_io;
      t_regmem;
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule